// File: doc/BRIEF.md
# Open-Collector Serial Bus Byte Sender

This block puts one byte onto a three-wire open-collector bus made of clock, data and attention lines. It only ever pulls lines down: each of its two line outputs is a pull-down enable, so a 1 on an output means the line is held low and a 0 means the line is left to the pull-up. It watches the data line through a debouncer that accepts a new level only after consecutive samples agree. It never touches the attention line. When a transfer is in attention mode, the caller has already asserted attention. After an error, the caller releases attention.

A transfer begins with a one-cycle `start_i` that carries the byte, a last-byte flag and an attention-mode flag. In attention mode the sender first holds the clock low with data released for a fixed time. It then releases data and checks for a listener: a present listener holds data low. Next it releases the clock and waits for the listener to release data, which means ready. For a last byte, it keeps the clock released until the listener has pulled data low once and released it again. It then clocks out eight bits, least significant first. After the eighth bit it waits a bounded time for the listener to pull data low as a frame acknowledge.

When the transfer ends, the block raises `done_o` for one cycle. A status code on `status_o` then stays valid until the next start.

Top module: `sbt_byte_tx`

## Requirements
- R1: After reset, both pull-down enables are 0, and `busy_o`, `done_o` and `status_o` are 0.
- R2: In attention mode the clock is held low with data released for at least `ATN_CYC` cycles before the clock is first released. Without attention mode, the clock is released after fewer than `ATN_CYC` cycles, given that `ATN_CYC` exceeds `SETTLE_CYC` plus a few cycles.
- R3: If data reads high once the sender has released it, no listener is present. The transfer then ends with status 0x80 and both lines released.
- R4: After the listener is found, the clock is released. It is not pulled low again until the debounced data line reads high.
- R5: For a last byte, the clock stays released after ready until data has been seen low and then high again. Only then does the first bit start.
- R6: Bits go out least significant first, eight per byte. Data carries the bit level (a 1 bit is released, a 0 bit is pulled low) from before the clock release until the clock is pulled low again.
- R7: If data is low when it is checked just before any bit, the transfer ends with status 0x03 (framing) and both lines released.
- R8: If the listener pulls data low within the acknowledge window after the eighth bit, the transfer ends with status 0x00. The clock stays pulled low and data is released.
- R9: If no acknowledge arrives within `SETTLE_CYC + ACK_CYC` cycles of the eighth clock fall, the transfer ends with status 0x03 and both lines released.
- R10: `busy_o` is high from the accepted start until the cycle of the one-cycle `done_o` pulse. A start request while busy is ignored and does not change the byte being sent.
- R11: `status_o` holds its value after `done_o` until the next accepted start, which clears it to 0x00.
- R12: A data-line change that lasts only one sample is never accepted as a new line level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a byte |
| byte_i | input | 8 | Byte to send, taken when start is accepted |
| eoi_i | input | 1 | Marks the byte as the last of a message |
| atn_mode_i | input | 1 | Byte is sent under attention, so add the initial clock hold |
| data_line_i | input | 1 | Sensed level of the bus data line |
| clk_pd_o | output | 1 | Pull-down enable for the bus clock line |
| data_pd_o | output | 1 | Pull-down enable for the bus data line |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| status_o | output | 8 | 0x00 sent, 0x80 no listener, 0x03 framing or no acknowledge |

## Verification
The assertions assume that the sensed data line is synchronous to `clk`. They also assume that the listener reacts to the line after it changes rather than racing it. In particular, the listener does not pull data low in the settle interval between a clock fall and the pre-bit check unless it means to signal an error. The bench listener changes the data line only at falling clock edges, and always at least one cycle after the clock change it is answering. Its only one-cycle pulse is the deliberate glitch that tests the debouncer. The bench keeps all of its delays well inside the settle and acknowledge windows, apart from the runs that are meant to violate them.

// File: rtl/sbt_pkg.sv
// Shared definitions for the serial bus byte sender.
// Assumes a byte-wide payload; the bit index width derives from it.
package sbt_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    // Result codes reported on the status output
    localparam logic [7:0] STAT_OK    = 8'h00;
    localparam logic [7:0] STAT_FRAME = 8'h03;
    localparam logic [7:0] STAT_NODEV = 8'h80;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ATN,
        S_PRES,
        S_READY,
        S_EOI_LO,
        S_EOI_HI,
        S_GAP,
        S_SETUP,
        S_CELL,
        S_ACK_SET,
        S_ACK
    } sbt_state_e;

endpackage

// File: rtl/sbt_debounce.sv
// Line filter: accepts a new level only after NSAMP consecutive equal
// samples. Assumes the input is already synchronous to clk. Idle level
// after reset is high (released bus line).
module sbt_debounce #(
    parameter int NSAMP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);

    logic [NSAMP-1:0] shreg_q;
    logic             level_q;

    // Sample history shift register
    always_ff @(posedge clk) begin
        if (!rst_n) shreg_q <= '1;
        else        shreg_q <= {shreg_q[NSAMP-2:0], line_i};
    end

    // Accept a level only when every stored sample agrees
    always_ff @(posedge clk) begin
        if (!rst_n)           level_q <= 1'b1;
        else if (&shreg_q)    level_q <= 1'b1;
        else if (~|shreg_q)   level_q <= 1'b0;
    end

    assign level_o = level_q;

    AST_DEB_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(&shreg_q) || $past(~|shreg_q))); // R12

endmodule

// File: rtl/sbt_timer.sv
// Down-counting delay timer. A load starts a wait of load_val+1 cycles.
// expired_o is high while the count is zero. Assumes load_val >= 1.
module sbt_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    // Load or count down, stopping at zero
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !expired_o); // R9

endmodule

// File: rtl/sbt_fsm.sv
// Transfer sequencer: attention hold, listener detect, ready and last-byte
// handshakes, eight bit cells, and the frame acknowledge wait. Line
// outputs are registered pull-down enables. Assumes a debounced data level
// and a timer that expires load_val+1 cycles after load.
module sbt_fsm
    import sbt_pkg::*;
#(
    parameter int TW         = 10,
    parameter int SETUP_CYC  = 8,
    parameter int CELL_CYC   = 8,
    parameter int ATN_CYC    = 1000,
    parameter int ACK_CYC    = 120,
    parameter int SETTLE_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              eoi_i,
    input  logic              atn_mode_i,
    input  logic              deb_i,
    input  logic              tmr_done_i,
    output logic              tmr_load_o,
    output logic [TW-1:0]     tmr_val_o,
    output logic              clk_pd_o,
    output logic              data_pd_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [7:0]        status_o
);

    localparam logic [TW-1:0] T_SETUP  = TW'(SETUP_CYC);
    localparam logic [TW-1:0] T_CELL   = TW'(CELL_CYC);
    localparam logic [TW-1:0] T_ATN    = TW'(ATN_CYC);
    localparam logic [TW-1:0] T_ACK    = TW'(ACK_CYC);
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

    sbt_state_e        state_q, state_d;
    logic              clk_pd_q, clk_pd_d;
    logic              data_pd_q, data_pd_d;
    logic              busy_q, busy_d;
    logic              done_q, done_d;
    logic [7:0]        status_q, status_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [BYTE_W-1:0] byte_q, byte_d;
    logic              eoi_q, eoi_d;

    // Next-state, line drive and timer control decode
    always_comb begin
        state_d    = state_q;
        clk_pd_d   = clk_pd_q;
        data_pd_d  = data_pd_q;
        busy_d     = busy_q;
        done_d     = 1'b0;
        status_d   = status_q;
        idx_d      = idx_q;
        byte_d     = byte_q;
        eoi_d      = eoi_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = T_SETTLE;
        case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    byte_d     = byte_i;
                    eoi_d      = eoi_i;
                    busy_d     = 1'b1;
                    status_d   = STAT_OK;
                    idx_d      = '0;
                    clk_pd_d   = 1'b1;
                    data_pd_d  = 1'b0;
                    tmr_load_o = 1'b1;
                    if (atn_mode_i) begin
                        state_d   = S_ATN;
                        tmr_val_o = T_ATN;
                    end else begin
                        state_d   = S_PRES;
                    end
                end
            end
            S_ATN: begin
                if (tmr_done_i) begin
                    state_d    = S_PRES;
                    tmr_load_o = 1'b1;
                end
            end
            S_PRES: begin
                if (tmr_done_i) begin
                    if (deb_i) begin
                        state_d   = S_IDLE;
                        clk_pd_d  = 1'b0;
                        data_pd_d = 1'b0;
                        busy_d    = 1'b0;
                        done_d    = 1'b1;
                        status_d  = STAT_NODEV;
                    end else begin
                        state_d  = S_READY;
                        clk_pd_d = 1'b0;
                    end
                end
            end
            S_READY: begin
                if (deb_i) begin
                    if (eoi_q) begin
                        state_d = S_EOI_LO;
                    end else begin
                        state_d    = S_GAP;
                        clk_pd_d   = 1'b1;
                        tmr_load_o = 1'b1;
                    end
                end
            end
            S_EOI_LO: begin
                if (!deb_i) state_d = S_EOI_HI;
            end
            S_EOI_HI: begin
                if (deb_i) begin
                    state_d    = S_GAP;
                    clk_pd_d   = 1'b1;
                    tmr_load_o = 1'b1;
                end
            end
            S_GAP: begin
                if (tmr_done_i) begin
                    if (!deb_i) begin
                        state_d   = S_IDLE;
                        clk_pd_d  = 1'b0;
                        data_pd_d = 1'b0;
                        busy_d    = 1'b0;
                        done_d    = 1'b1;
                        status_d  = STAT_FRAME;
                    end else begin
                        state_d    = S_SETUP;
                        data_pd_d  = ~byte_q[idx_q];
                        tmr_load_o = 1'b1;
                        tmr_val_o  = T_SETUP;
                    end
                end
            end
            S_SETUP: begin
                if (tmr_done_i) begin
                    state_d    = S_CELL;
                    clk_pd_d   = 1'b0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = T_CELL;
                end
            end
            S_CELL: begin
                if (tmr_done_i) begin
                    clk_pd_d   = 1'b1;
                    data_pd_d  = 1'b0;
                    tmr_load_o = 1'b1;
                    if (idx_q == LAST_IDX) begin
                        state_d = S_ACK_SET;
                    end else begin
                        state_d = S_GAP;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            S_ACK_SET: begin
                if (tmr_done_i) begin
                    state_d    = S_ACK;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = T_ACK;
                end
            end
            S_ACK: begin
                if (!deb_i) begin
                    state_d  = S_IDLE;
                    busy_d   = 1'b0;
                    done_d   = 1'b1;
                    status_d = STAT_OK;
                end else if (tmr_done_i) begin
                    state_d   = S_IDLE;
                    clk_pd_d  = 1'b0;
                    data_pd_d = 1'b0;
                    busy_d    = 1'b0;
                    done_d    = 1'b1;
                    status_d  = STAT_FRAME;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            clk_pd_q  <= 1'b0;
            data_pd_q <= 1'b0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            status_q  <= STAT_OK;
            idx_q     <= '0;
            byte_q    <= '0;
            eoi_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            clk_pd_q  <= clk_pd_d;
            data_pd_q <= data_pd_d;
            busy_q    <= busy_d;
            done_q    <= done_d;
            status_q  <= status_d;
            idx_q     <= idx_d;
            byte_q    <= byte_d;
            eoi_q     <= eoi_d;
        end
    end

    assign clk_pd_o  = clk_pd_q;
    assign data_pd_o = data_pd_q;
    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign status_o  = status_q;

    AST_ATN_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ATN) |-> (clk_pd_q && !data_pd_q)); // R2
    AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && status_q != STAT_OK) |-> (!clk_pd_q && !data_pd_q)); // R3
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READY && !deb_i) |=> !clk_pd_q); // R4
    AST_EOI_CLK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EOI_LO || state_q == S_EOI_HI) |-> !clk_pd_q); // R5
    AST_CELL_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CELL && $past(state_q) == S_CELL) |-> $stable(data_pd_q)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R10
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i) |=> $stable(byte_q)); // R10
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start_i) |=> $stable(status_q)); // R11

endmodule

// File: rtl/sbt_byte_tx.sv
// Top of the serial bus byte sender. Wires the data-line debouncer, the
// delay timer and the sequencer. Assumes data_line_i is synchronous to
// clk and that SETTLE_CYC exceeds the debounce latency (DEB_SAMPLES + 2).
module sbt_byte_tx #(
    parameter int SETUP_CYC   = 8,
    parameter int CELL_CYC    = 8,
    parameter int ATN_CYC     = 1000,
    parameter int ACK_CYC     = 120,
    parameter int SETTLE_CYC  = 6,
    parameter int DEB_SAMPLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    input  logic       eoi_i,
    input  logic       atn_mode_i,
    input  logic       data_line_i,
    output logic       clk_pd_o,
    output logic       data_pd_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] status_o
);

    localparam int MAX_A   = (SETUP_CYC > CELL_CYC) ? SETUP_CYC : CELL_CYC;
    localparam int MAX_B   = (ATN_CYC > ACK_CYC) ? ATN_CYC : ACK_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_MAX = (MAX_C > SETTLE_CYC) ? MAX_C : SETTLE_CYC;
    localparam int TW      = $clog2(TMR_MAX + 1);

    logic          deb_data;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;

    sbt_debounce #(.NSAMP(DEB_SAMPLES)) deb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (data_line_i),
        .level_o (deb_data)
    );

    sbt_timer #(.W(TW)) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_done)
    );

    sbt_fsm #(
        .TW         (TW),
        .SETUP_CYC  (SETUP_CYC),
        .CELL_CYC   (CELL_CYC),
        .ATN_CYC    (ATN_CYC),
        .ACK_CYC    (ACK_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .byte_i     (byte_i),
        .eoi_i      (eoi_i),
        .atn_mode_i (atn_mode_i),
        .deb_i      (deb_data),
        .tmr_done_i (tmr_done),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .clk_pd_o   (clk_pd_o),
        .data_pd_o  (data_pd_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .status_o   (status_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!clk_pd_o && !data_pd_o && !busy_o && !done_o && status_o == 8'h00)); // R1

endmodule

// File: tb/sbt_byte_tx_tb_top.sv
// Bench: a behavioural listener answers each transfer; expected values
// follow from the requirements.
module sbt_byte_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ATN_T      = 40;
    localparam int ACK_T      = 120;
    localparam int SETTLE_T   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx = 8'h00;
    logic       eoi = 1'b0;
    logic       atn = 1'b0;
    logic       dev_pd = 1'b0;
    logic       clk_pd, data_pd, busy, done;
    logic [7:0] status;
    logic       data_line;

    assign data_line = !(data_pd | dev_pd);

    sbt_byte_tx #(.ATN_CYC(ATN_T), .ACK_CYC(ACK_T), .SETTLE_CYC(SETTLE_T)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .byte_i      (tx),
        .eoi_i       (eoi),
        .atn_mode_i  (atn),
        .data_line_i (data_line),
        .clk_pd_o    (clk_pd),
        .data_pd_o   (data_pd),
        .busy_o      (busy),
        .done_o      (done),
        .status_o    (status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Per-run observations
    logic [7:0] r_got;
    int         r_nbits, r_lowcyc, r_falls, r_busy_gaps;
    logic [7:0] r_status, r_st_start;
    logic       r_clk_after, r_data_after, r_timeout;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One transfer with a listener: present, bad_bit (-1 none), ack delay (-1 none)
    task automatic run_tx(input logic [7:0] b, input bit e, input bit a, input bit present,
                          input int bad_bit, input int ack_dly, input bit glitch, input bit poke);
        int  phase = 0;
        int  cnt = 0;
        int  it = 0;
        bit  bc, bd, pbc;
        r_got = 8'h00; r_nbits = 0; r_lowcyc = 0; r_falls = 0; r_busy_gaps = 0;
        @(negedge clk);
        dev_pd = present; tx = b; eoi = e; atn = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_st_start = status;
        pbc = !clk_pd;
        while (it < 5000) begin
            bc = !clk_pd;
            bd = data_line;
            if (done) break;
            if (!busy) r_busy_gaps++;
            if (poke && it == 30) begin start = 1'b1; tx = ~b; end
            if (poke && it == 31) start = 1'b0;
            case (phase)
                0: begin
                    if (!bc) r_lowcyc++;
                    else begin phase = 1; cnt = 0; end
                end
                1: begin
                    cnt++;
                    if (!bc) r_falls++;
                    if (glitch && cnt == 3) dev_pd = 1'b0;
                    if (glitch && cnt == 4) dev_pd = 1'b1;
                    if (cnt == 20) begin dev_pd = 1'b0; phase = e ? 2 : 4; cnt = 0; end
                end
                2: begin
                    cnt++;
                    if (!bc) r_falls++;
                    if (cnt == 30) begin dev_pd = 1'b1; phase = 3; cnt = 0; end
                end
                3: begin
                    cnt++;
                    if (!bc) r_falls++;
                    if (cnt == 10) begin dev_pd = 1'b0; phase = 4; end
                end
                4: begin
                    if (bc && !pbc) begin
                        if (r_nbits < 8) r_got[r_nbits] = bd;
                        r_nbits++;
                    end else if (!bc && pbc) begin
                        if (r_nbits == bad_bit) dev_pd = 1'b1;
                        if (r_nbits == 8) begin phase = 5; cnt = 0; end
                    end
                end
                default: begin
                    cnt++;
                    if (cnt == ack_dly) dev_pd = 1'b1;
                end
            endcase
            pbc = bc;
            it++;
            @(negedge clk);
        end
        r_timeout    = (it >= 5000);
        r_status     = status;
        r_clk_after  = clk_pd;
        r_data_after = data_pd;
        @(negedge clk);
        chk(!busy && !done, "R10 busy and done low after end", {busy, done}, 0);
        chk(r_st_start == 8'h00, "R11 status cleared by start", r_st_start, 0);
        chk(!r_timeout, "R10 transfer ended", r_timeout, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({clk_pd, data_pd, busy, done} == 4'b0000, "R1 outputs idle", {clk_pd, data_pd, busy, done}, 0);
        chk(status == 8'h00, "R1 status zero", status, 0);

        // R6/R8/R2/R4/R5: sweep bytes over eoi and attention combinations
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b;
            bit e, a;
            b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 53 + 7) & 255);
            e = i[0];
            a = i[1];
            run_tx(b, e, a, 1'b1, -1, 5, 1'b0, 1'b0);
            chk(r_got == b, "R6 byte LSB first", r_got, b);
            chk(r_nbits == 8, "R6 eight bit cells", r_nbits, 8);
            chk(r_status == 8'h00, "R8 ack status", r_status, 0);
            chk(r_clk_after && !r_data_after, "R8 clock held, data released", {r_clk_after, r_data_after}, 2);
            chk(r_falls == 0, e ? "R5 clock free during last-byte handshake" : "R4 clock free until ready",
                r_falls, 0);
            if (a) chk(r_lowcyc >= ATN_T, "R2 attention hold length", r_lowcyc, ATN_T);
            else   chk(r_lowcyc <  ATN_T, "R2 no attention hold", r_lowcyc, 0);
            chk(r_busy_gaps == 0, "R10 busy through transfer", r_busy_gaps, 0);
        end

        // R3: no listener
        run_tx(8'hA5, 1'b0, 1'b1, 1'b0, -1, -1, 1'b0, 1'b0);
        chk(r_status == 8'h80, "R3 no-listener status", r_status, 8'h80);
        chk(!r_clk_after && !r_data_after, "R3 lines released", {r_clk_after, r_data_after}, 0);
        chk(r_nbits == 0, "R3 no bits sent", r_nbits, 0);

        // R11: status held while idle
        repeat (25) @(negedge clk);
        chk(status == 8'h80 && !done, "R11 status held", status, 8'h80);

        // R7: listener holds data low after third bit
        run_tx(8'h3C, 1'b0, 1'b0, 1'b1, 3, -1, 1'b0, 1'b0);
        chk(r_status == 8'h03, "R7 framing status", r_status, 3);
        chk(r_nbits == 3, "R7 stopped before fourth bit", r_nbits, 3);
        chk(!r_clk_after && !r_data_after, "R7 lines released", {r_clk_after, r_data_after}, 0);

        // R9: no acknowledge, and acknowledge too late
        run_tx(8'h5A, 1'b1, 1'b0, 1'b1, -1, -1, 1'b0, 1'b0);
        chk(r_status == 8'h03, "R9 missing ack status", r_status, 3);
        chk(r_nbits == 8, "R9 all bits sent", r_nbits, 8);
        chk(!r_clk_after && !r_data_after, "R9 lines released", {r_clk_after, r_data_after}, 0);
        run_tx(8'h81, 1'b0, 1'b0, 1'b1, -1, SETTLE_T + ACK_T + 30, 1'b0, 1'b0);
        chk(r_status == 8'h03, "R9 late ack status", r_status, 3);

        // R8: acknowledge late but inside the window
        run_tx(8'h96, 1'b0, 1'b1, 1'b1, -1, 100, 1'b0, 1'b0);
        chk(r_status == 8'h00, "R8 slow ack accepted", r_status, 0);
        chk(r_got == 8'h96, "R6 byte with slow ack", r_got, 8'h96);

        // R12: one-sample glitch on data while waiting for ready
        run_tx(8'h42, 1'b0, 1'b0, 1'b1, -1, 5, 1'b1, 1'b0);
        chk(r_falls == 0, "R12 glitch not taken as ready", r_falls, 0);
        chk(r_status == 8'h00 && r_got == 8'h42, "R12 transfer intact after glitch", r_got, 8'h42);

        // R10: start while busy is ignored
        run_tx(8'hC3, 1'b1, 1'b0, 1'b1, -1, 5, 1'b0, 1'b1);
        chk(r_got == 8'hC3, "R10 start ignored while busy", r_got, 8'hC3);
        chk(r_status == 8'h00, "R10 transfer completes", r_status, 0);
        repeat (10) @(negedge clk);
        chk(!busy, "R10 no extra transfer started", busy, 0);

        report();
        $finish;
    end

endmodule